// File: doc/BRIEF.md
# Character Scan Timer

This block sets the pace of a time-multiplexed eight-position character display. A free-running oscillator tick, given as a one-cycle enable on the system clock, feeds a pre-divider of 64 counts. Each pre-divider wrap moves a character slot counter one place. The slot counter scans positions 1 through 8 and then starts again. The slot value is the read address for the display memory. It is also decoded into a one-hot set of character drives.

Each slot opens with a short blanking gap, taken from the pre-divider, so that the old glyph never lights the new position. Drives are also removed while a host write is in progress and while an off request is held. An off request clears both counters, so the scan restarts cleanly from the first position when it is released. Font lookup and the analog drivers sit outside this block.

Top module: `charscan_timer`

## Requirements
- R1: The pre-divider counts only on cycles with `osc_tick` high. On the 64th counted tick it returns to 0 and advances the slot counter by one. Without ticks, neither counter moves.
- R2: The slot counter runs 0,1,...,7 and then back to 0. `rd_addr` always equals the slot value. When a drive is active, `char_en` bit k is set for slot k, so bit 0 is character 1.
- R3: While the pre-divider count is 0 (the first tick period of each slot), `char_en` is 8'b0 and `seg_en` is 0.
- R4: Outside blanking, write and off, exactly one bit of `char_en` is high and `seg_en` is 1.
- R5: While `wr_active` is high, `char_en` is 8'b0 and `seg_en` is 0 in the same cycle. The counters keep running.
- R6: While `off_req` is high, `char_en` is 8'b0 and `seg_en` is 0 in the same cycle. Both counters are cleared at the next clock edge, and ticks are ignored.
- R7: After `off_req` is released, the scan resumes at slot 0 with pre-divider count 0. It is therefore blanked for one tick period, and then character 1 is driven.
- R8: A synchronous active-high `rst` sets both counters to 0, which leaves the outputs blanked with `rd_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| osc_tick | input | 1 | One-cycle oscillator tick enable |
| off_req | input | 1 | Shutdown request: darkens outputs and clears the counters |
| wr_active | input | 1 | Host write in progress: darkens outputs |
| rd_addr | output | 3 | Display memory read address (current slot) |
| char_en | output | 8 | One-hot character drives; bit 0 is the leftmost position |
| seg_en | output | 1 | Segment drive enable |

## Verification
The embedded properties check several rules on every cycle:
- the pre-divider wrap and the stall without ticks;
- the slot wrap from 7 to 0;
- that at most one character is driven, and that it matches `rd_addr`;
- darkness during writes and off;
- the clear one edge after off.

Other behaviour can only be shown by the bench scenarios. These are the order of a full scan and the exact 64-tick dwell per slot under dense and sparse tick patterns. They also cover the position of the blanking gap, the counters running on through a write, and the restart from character 1 after off is released.

// File: rtl/charscan_pkg.sv
package charscan_pkg;

    localparam int DEF_PRE_DIV = 64;
    localparam int DEF_CHARS   = 8;
    localparam int DEF_BLANK   = 1;

    // Why the drives are currently dark (or not)
    typedef enum logic [1:0] {
        GATE_LIVE  = 2'd0,
        GATE_BLANK = 2'd1,
        GATE_WRITE = 2'd2,
        GATE_OFF   = 2'd3
    } gate_e;

    // Events produced by the pre-divider each cycle
    typedef struct packed {
        logic wrap;   // slot advance request
        logic blank;  // inside inter-character gap
    } prediv_evt_t;

    // Shutdown outranks writes, writes outrank the blanking gap
    function automatic gate_e pick_gate(input logic off, input logic wr,
                                        input logic blank);
        gate_e g;
        if (off)        g = GATE_OFF;
        else if (wr)    g = GATE_WRITE;
        else if (blank) g = GATE_BLANK;
        else            g = GATE_LIVE;
        return g;
    endfunction

endpackage

// File: rtl/charscan_prediv.sv
module charscan_prediv
    import charscan_pkg::*;
#(
    parameter int DIV   = DEF_PRE_DIV,
    parameter int BLANK = DEF_BLANK
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        off,
    output prediv_evt_t evt_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);
    localparam logic [W-1:0] GAP  = W'(BLANK);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || off) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        evt_o.wrap  = tick && !off && (cnt == LAST);
        evt_o.blank = (cnt < GAP);
    end

    // R1: a counted tick at the last count wraps to zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && !off && cnt == LAST) |=> (cnt == '0));
    // R1: no tick, no movement
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!tick && !off) |=> $stable(cnt));
    // R6: off clears the pre-divider on the next edge
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        off |=> (cnt == '0));

endmodule

// File: rtl/charscan_slot.sv
module charscan_slot #(
    parameter int N = charscan_pkg::DEF_CHARS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          adv,
    input  logic                          off,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] slot
);
    localparam int W = (N > 1) ? $clog2(N) : 1;
    localparam logic [W-1:0] LAST = W'(N - 1);

    always_ff @(posedge clk) begin
        if (rst || off) begin
            slot <= '0;
        end else if (adv) begin
            slot <= (slot == LAST) ? '0 : slot + 1'b1;
        end
    end

    // R2: the last position wraps to the first
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && !off && slot == LAST) |=> (slot == '0));
    // R1: the slot moves only on a pre-divider wrap
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!adv && !off) |=> $stable(slot));
    // R6: off clears the slot counter
    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        off |=> (slot == '0));

endmodule

// File: rtl/charscan_drive.sv
module charscan_drive
    import charscan_pkg::*;
#(
    parameter int N = DEF_CHARS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [((N > 1) ? $clog2(N) : 1)-1:0] slot,
    input  logic                          blank,
    input  logic                          wr,
    input  logic                          off,
    output logic [N-1:0]                  char_en,
    output logic                          seg_en,
    output gate_e                         gate
);
    localparam int W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] decoded;

    generate
        for (genvar i = 0; i < N; i++) begin : g_dec
            assign decoded[i] = (slot == W'(i));
        end
    endgenerate

    always_comb begin
        gate    = pick_gate(off, wr, blank);
        char_en = (gate == GATE_LIVE) ? decoded : '0;
        seg_en  = (gate == GATE_LIVE);
    end

    // R4: never more than one character driven
    p_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(char_en));
    // R4: segments enabled exactly when a character is driven
    p_pair_r4: assert property (@(posedge clk) disable iff (rst)
        seg_en == (char_en != '0));
    // R5: a write darkens the drives
    p_write_dark_r5: assert property (@(posedge clk) disable iff (rst)
        wr |-> (char_en == '0 && !seg_en));
    // R3: the blanking gap darkens the drives
    p_gap_dark_r3: assert property (@(posedge clk) disable iff (rst)
        blank |-> (char_en == '0));

endmodule

// File: rtl/charscan_timer.sv
module charscan_timer
    import charscan_pkg::*;
#(
    parameter int PRE_DIV     = DEF_PRE_DIV,
    parameter int N_CHARS     = DEF_CHARS,
    parameter int BLANK_TICKS = DEF_BLANK
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 osc_tick,
    input  logic                                 off_req,
    input  logic                                 wr_active,
    output logic [((N_CHARS > 1) ? $clog2(N_CHARS) : 1)-1:0] rd_addr,
    output logic [N_CHARS-1:0]                   char_en,
    output logic                                 seg_en
);
    localparam int SW = (N_CHARS > 1) ? $clog2(N_CHARS) : 1;

    prediv_evt_t    evt;
    logic [SW-1:0]  slot;
    gate_e          gate;

    charscan_prediv #(.DIV(PRE_DIV), .BLANK(BLANK_TICKS)) u_prediv (
        .clk   (clk),
        .rst   (rst),
        .tick  (osc_tick),
        .off   (off_req),
        .evt_o (evt)
    );

    charscan_slot #(.N(N_CHARS)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .adv  (evt.wrap),
        .off  (off_req),
        .slot (slot)
    );

    charscan_drive #(.N(N_CHARS)) u_drive (
        .clk     (clk),
        .rst     (rst),
        .slot    (slot),
        .blank   (evt.blank),
        .wr      (wr_active),
        .off     (off_req),
        .char_en (char_en),
        .seg_en  (seg_en),
        .gate    (gate)
    );

    assign rd_addr = slot;

    // R2: the driven character always matches the read address
    p_addr_match_r2: assert property (@(posedge clk) disable iff (rst)
        (char_en != '0) |-> char_en[rd_addr]);
    // R6: off darkens every output in the same cycle
    p_off_dark_r6: assert property (@(posedge clk) disable iff (rst)
        off_req |-> (char_en == '0 && !seg_en && gate == GATE_OFF));
    // R7: after off the read address restarts at the first position
    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        off_req |=> (rd_addr == '0));

endmodule

// File: tb/sim_charscan_timer.sv
module sim_charscan_timer;

    typedef struct {
        logic [7:0] ch;
        logic       seg;
        logic [2:0] addr;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       off_req = 1'b0;
    logic       wr_active = 1'b0;
    logic [2:0] rd_addr;
    logic [7:0] char_en;
    logic       seg_en;

    int checks = 0;
    int failures = 0;
    int m_pre = 0;
    int m_slot = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    charscan_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .off_req   (off_req),
        .wr_active (wr_active),
        .rd_addr   (rd_addr),
        .char_en   (char_en),
        .seg_en    (seg_en)
    );

    // Driver: apply inputs, predict outputs from the reference model
    task automatic step(input logic t, input logic o, input logic w,
                        input string tag);
        exp_t e;
        @(negedge clk);
        osc_tick  = t;
        off_req   = o;
        wr_active = w;
        #1;
        e.addr = 3'(m_slot);
        if (o || w || m_pre < 1) begin
            e.ch  = 8'h00;
            e.seg = 1'b0;
        end else begin
            e.ch  = 8'h01 << m_slot;
            e.seg = 1'b1;
        end
        if (tag != "")      e.tag = tag;
        else if (o)         e.tag = "R6";
        else if (w)         e.tag = "R5";
        else if (m_pre < 1) e.tag = "R3";
        else                e.tag = "R2 R4";
        q.push_back(e);
        if (o) begin
            m_pre  = 0;
            m_slot = 0;
        end else if (t) begin
            if (m_pre == 63) begin
                m_pre  = 0;
                m_slot = (m_slot + 1) % 8;
            end else begin
                m_pre = m_pre + 1;
            end
        end
    endtask

    // Monitor: compare the design against queued predictions
    always @(negedge clk) begin
        #3;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (char_en !== e.ch || seg_en !== e.seg || rd_addr !== e.addr) begin
                failures++;
                $display("FAIL %s: char_en=%h seg_en=%b rd_addr=%0d expected char_en=%h seg_en=%b rd_addr=%0d",
                         e.tag, char_en, seg_en, rd_addr, e.ch, e.seg, e.addr);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state, and R1: no ticks means no movement
        step(1'b0, 1'b0, 1'b0, "R8");
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, "R1");
        // Dense ticks across two full scans (R2, R3, R4)
        for (int i = 0; i < 1100; i++) step(1'b1, 1'b0, 1'b0, "");
        // R1: sparse ticks, one every third cycle
        for (int i = 0; i < 600; i++) step(i % 3 == 0, 1'b0, 1'b0, (i % 3 == 0) ? "" : "R1");
        // R5: writes mid-slot while the scan keeps running
        for (int i = 0; i < 90; i++) step(1'b1, 1'b0, 1'b1, "");
        for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, "");
        // R6: off with ticks present, also together with a write
        for (int i = 0; i < 10; i++) step(1'b1, 1'b1, i > 5, "");
        // R7: restart from character 1 after release
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 1'b0, "");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule